// File: doc/BRIEF.md
# Pre-Bond Via Self-Test Sequencer

This controller runs the whole self-test of a die's through-silicon vias before the die is stacked. It drives an external scan chain: shift mode, a load strobe that drives each via from its flop, a capture strobe that samples the via response into the following flop, and a timed charge pulse. It also supplies the serial input bit and compares the serial output against expected data.

A single start pulse runs a fixed flow. First comes a shift-only integrity check of the chain, run twice: once with all zeros and once with all ones. Next comes the stuck-at test, which also catches hard shorts to the substrate. Then comes the near-short test, where a leaky via cannot charge within the pulse window. An extra via test stage runs last, and only when its enable parameter is set.

The first mismatching bit ends the run. The die is then marked bad and the code of the failing stage is recorded. Done, fail and the stage code are held until the next start.

Top module: `via_bist_seq`

## Requirements
- R1: While reset is asserted and after its release, all mode outputs, scan_si, done, fail and fail_stage are 0.
- R2: A start in idle or done begins the chain check on the next clock. The chain check is two passes of CHAIN_LEN shift-in cycles followed by CHAIN_LEN shift-out cycles. The first pass shifts all zeros and the second all ones. Load and capture are never asserted during the chain check.
- R3: Each via stage is a sequence of CHAIN_LEN shift-in cycles, one load cycle, one capture cycle and CHAIN_LEN shift-out cycles. The stages run in the order stuck-at, near-short, extra. Pattern bit 0 is driven first on scan_si, and scan_si is 0 during shift-out.
- R4: pulse_en is high only during the capture cycle of the near-short stage.
- R5: Each shift-out cycle compares scan_so with expected bit k, where k is the shift-out cycle index and bit 0 comes first. On the first mismatch the next cycle shows done=1 and fail=1, with fail_stage coded as 0 for the chain check, 1 for stuck-at, 2 for near-short and 3 for extra.
- R6: A chain check failure ends the run before any load cycle.
- R7: When every enabled stage matches, the cycle after the last shift-out shows done=1, fail=0 and fail_stage=0.
- R8: done, fail and fail_stage hold until the next start, which clears them. A start while the run is busy is ignored.
- R9: With EXTRA_EN clear, the run ends after the near-short stage and no fault visible only to the extra stage is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a test run |
| scan_en | output | 1 | Chain shift mode |
| scan_si | output | 1 | Serial data into the chain |
| scan_so | input | 1 | Serial data out of the chain |
| load_en | output | 1 | Drives each via from its flop |
| capt_en | output | 1 | Captures via responses into the next flop |
| pulse_en | output | 1 | Timed charge window for the near-short test |
| done | output | 1 | Run finished |
| fail | output | 1 | Die rejected |
| fail_stage | output | 2 | Code of the failing stage |

## Verification
A wrong cycle count or a wrong stage register shows up at the mode outputs within one shift window. Examples are a load during the chain check, a missing pulse, or a stage sequence that is one cycle short. The bench compares those outputs on every cycle against a behavioural chain-and-flow model. A wrong expected bit or a wrong stop decision shows up as done and fail at the wrong cycle, or as a wrong stage code. Faults are injected into a chain model so that each stage in turn is the first to see a mismatch: a broken chain bit, a via stuck low, a leaky via and a via stuck high.

// File: rtl/via_bist_seq.sv
`timescale 1ns/1ps
module via_bist_seq #(
  parameter int CHAIN_LEN = 8,
  parameter bit EXTRA_EN = 1'b0,
  parameter logic [CHAIN_LEN-1:0] SAF_PAT = 'hA5,
  parameter logic [CHAIN_LEN-1:0] SAF_EXP = 'h4B,
  parameter logic [CHAIN_LEN-1:0] NS_PAT  = 'hFF,
  parameter logic [CHAIN_LEN-1:0] NS_EXP  = 'hFF,
  parameter logic [CHAIN_LEN-1:0] XT_PAT  = 'h3C,
  parameter logic [CHAIN_LEN-1:0] XT_EXP  = 'h78
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       scan_en,
  output logic       scan_si,
  input  logic       scan_so,
  output logic       load_en,
  output logic       capt_en,
  output logic       pulse_en,
  output logic       done,
  output logic       fail,
  output logic [1:0] fail_stage
);
  localparam int CW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(CHAIN_LEN - 1);
  localparam logic [1:0] LAST_STAGE = EXTRA_EN ? 2'd3 : 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SHIN, S_LOAD, S_CAPT, S_SHOUT, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] stage;
  logic pass1;
  logic [CHAIN_LEN-1:0] pat, expv;

  always_comb begin
    case (stage)
      2'd0:    begin pat = {CHAIN_LEN{pass1}}; expv = {CHAIN_LEN{pass1}}; end
      2'd1:    begin pat = SAF_PAT; expv = SAF_EXP; end
      2'd2:    begin pat = NS_PAT;  expv = NS_EXP;  end
      default: begin pat = XT_PAT;  expv = XT_EXP;  end
    endcase
  end

  wire bit_last = (cnt == LAST_BIT);
  wire mism = (scan_so != expv[cnt]);

  assign scan_en  = (st == S_SHIN) || (st == S_SHOUT);
  assign scan_si  = (st == S_SHIN) && pat[cnt];
  assign load_en  = (st == S_LOAD);
  assign capt_en  = (st == S_CAPT);
  assign pulse_en = (st == S_CAPT) && (stage == 2'd2);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      stage <= 2'd0;
      pass1 <= 1'b0;
      fail <= 1'b0;
      fail_stage <= 2'd0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st <= S_SHIN;
            cnt <= '0;
            stage <= 2'd0;
            pass1 <= 1'b0;
            fail <= 1'b0;
            fail_stage <= 2'd0;
          end
        S_SHIN:
          if (bit_last) begin
            cnt <= '0;
            st <= (stage == 2'd0) ? S_SHOUT : S_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_LOAD: st <= S_CAPT;
        S_CAPT: st <= S_SHOUT;
        S_SHOUT:
          if (mism) begin
            st <= S_DONE;
            fail <= 1'b1;
            fail_stage <= stage;
          end else if (!bit_last) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (stage == 2'd0 && !pass1) begin
              pass1 <= 1'b1;
              st <= S_SHIN;
            end else if (stage == LAST_STAGE) begin
              st <= S_DONE;
            end else begin
              stage <= stage + 2'd1;
              pass1 <= 1'b0;
              st <= S_SHIN;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: at most one chain mode at a time
  a_r2_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_en, load_en, capt_en}));
  // R3: capture directly follows load
  a_r3_capt_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    capt_en |-> $past(load_en));
  // R6: the chain check never loads the vias
  a_r6_no_load_in_chain: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (stage != 2'd0));
  // R4: the charge pulse sits inside a capture cycle
  a_r4_pulse_in_capt: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> capt_en);
  // R5: a mismatch ends the run with fail set
  a_r5_stop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !scan_si && (st == S_SHOUT) && mism) |=> (done && fail));
  a_r5_fail_means_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  // R8: results hold until a new start
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(fail_stage)));
  // R9: the extra stage is reached only when enabled
  a_r9_extra_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd3) |-> EXTRA_EN);
endmodule

// File: tb/tb_via_bist_seq.sv
`timescale 1ns/1ps
module tb_chain #(parameter int N = 8) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_en,
  input  logic       si,
  input  logic       capt_en,
  input  logic       pulse_en,
  input  logic       brk_en,
  input  int         brk_pos,
  input  logic       brk_val,
  input  logic       v0_en,
  input  int         v0_pos,
  input  logic       v1_en,
  input  int         v1_pos,
  input  logic       lk_en,
  input  int         lk_pos,
  output logic       so
);
  logic [N-1:0] c, nx;
  assign so = c[0];
  always_comb begin
    nx = c;
    if (scan_en) begin
      for (int p = 0; p < N - 1; p++) nx[p] = c[p+1];
      nx[N-1] = si;
    end else if (capt_en) begin
      for (int p = 0; p < N; p++) begin
        logic v;
        v = c[p];
        if (v0_en && p == v0_pos) v = 1'b0;
        if (v1_en && p == v1_pos) v = 1'b1;
        if (lk_en && pulse_en && p == lk_pos) v = 1'b0;
        nx[(p + 1) % N] = v;
      end
    end
    if (brk_en) nx[brk_pos] = brk_val;
  end
  always_ff @(posedge clk) begin
    if (!rst_n) c <= '0;
    else c <= nx;
  end
endmodule

module tb_via_bist_seq;
  localparam int N = 8;
  localparam logic [N-1:0] SAFP = 8'hA5, SAFE = 8'h4B, NSP = 8'hFF, NSE = 8'hFF, XTP = 8'h3C, XTE = 8'h78;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #2.5 clk = ~clk;

  logic brk_en = 0, brk_val = 0, v0_en = 0, v1_en = 0, lk_en = 0;
  int brk_pos = 0, v0_pos = 0, v1_pos = 0, lk_pos = 0;

  logic se_a, si_a, so_a, ld_a, cp_a, pu_a, dn_a, fl_a;
  logic [1:0] cd_a;
  logic se_b, si_b, so_b, ld_b, cp_b, pu_b, dn_b, fl_b;
  logic [1:0] cd_b;

  via_bist_seq #(.CHAIN_LEN(N), .EXTRA_EN(1'b1), .SAF_PAT(SAFP), .SAF_EXP(SAFE),
    .NS_PAT(NSP), .NS_EXP(NSE), .XT_PAT(XTP), .XT_EXP(XTE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(se_a), .scan_si(si_a), .scan_so(so_a),
    .load_en(ld_a), .capt_en(cp_a), .pulse_en(pu_a), .done(dn_a), .fail(fl_a), .fail_stage(cd_a));
  via_bist_seq #(.CHAIN_LEN(N), .EXTRA_EN(1'b0), .SAF_PAT(SAFP), .SAF_EXP(SAFE),
    .NS_PAT(NSP), .NS_EXP(NSE), .XT_PAT(XTP), .XT_EXP(XTE)) dut_noext (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(se_b), .scan_si(si_b), .scan_so(so_b),
    .load_en(ld_b), .capt_en(cp_b), .pulse_en(pu_b), .done(dn_b), .fail(fl_b), .fail_stage(cd_b));

  tb_chain #(.N(N)) ch_a (.clk(clk), .rst_n(rst_n), .scan_en(se_a), .si(si_a), .capt_en(cp_a),
    .pulse_en(pu_a), .brk_en(brk_en), .brk_pos(brk_pos), .brk_val(brk_val), .v0_en(v0_en),
    .v0_pos(v0_pos), .v1_en(v1_en), .v1_pos(v1_pos), .lk_en(lk_en), .lk_pos(lk_pos), .so(so_a));
  tb_chain #(.N(N)) ch_b (.clk(clk), .rst_n(rst_n), .scan_en(se_b), .si(si_b), .capt_en(cp_b),
    .pulse_en(pu_b), .brk_en(brk_en), .brk_pos(brk_pos), .brk_val(brk_val), .v0_en(v0_en),
    .v0_pos(v0_pos), .v1_en(v1_en), .v1_pos(v1_pos), .lk_en(lk_en), .lk_pos(lk_pos), .so(so_b));

  int total = 0, fails = 0;
  // word: [8]scan_en [7]scan_si [6]load [5]capt [4]pulse [3]done [2]fail [1:0]stage
  logic [8:0] qa[$], qb[$];
  logic efa, efb;
  logic [1:0] eca, ecb;

  function automatic logic [N-1:0] force_brk(input logic [N-1:0] g);
    logic [N-1:0] r = g;
    if (brk_en) r[brk_pos] = brk_val;
    return r;
  endfunction

  function automatic logic [N-1:0] mshift(input logic [N-1:0] g, input logic b);
    return force_brk({b, g[N-1:1]});
  endfunction

  function automatic logic [N-1:0] mcap(input logic [N-1:0] g, input logic pulse);
    logic [N-1:0] r = g;
    for (int p = 0; p < N; p++) begin
      logic v = g[p];
      if (v0_en && p == v0_pos) v = 1'b0;
      if (v1_en && p == v1_pos) v = 1'b1;
      if (lk_en && pulse && p == lk_pos) v = 1'b0;
      r[(p + 1) % N] = v;
    end
    return force_brk(r);
  endfunction

  task automatic gen(input bit ext, ref logic [8:0] q[$], ref logic ef, ref logic [1:0] ec);
    logic [N-1:0] gc, pat, ex;
    int last;
    gc = force_brk('0);
    q.delete();
    ef = 1'b0;
    ec = 2'd0;
    last = ext ? 3 : 2;
    for (int s = 0; s <= last; s++) begin
      for (int pp = 0; pp < ((s == 0) ? 2 : 1); pp++) begin
        case (s)
          0: begin pat = {N{pp[0]}}; ex = {N{pp[0]}}; end
          1: begin pat = SAFP; ex = SAFE; end
          2: begin pat = NSP; ex = NSE; end
          default: begin pat = XTP; ex = XTE; end
        endcase
        for (int k = 0; k < N; k++) begin
          q.push_back({1'b1, pat[k], 7'b0});
          gc = mshift(gc, pat[k]);
        end
        if (s > 0) begin
          q.push_back(9'b001000000);
          q.push_back({3'b000, 1'b1, (s == 2), 4'b0});
          gc = mcap(gc, s == 2);
        end
        for (int k = 0; k < N; k++) begin
          q.push_back(9'b100000000);
          if (gc[0] != ex[k]) begin
            ef = 1'b1;
            ec = 2'(s);
            return;
          end
          gc = mshift(gc, 1'b0);
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string who, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, who, act, exp);
    end
  endtask

  task automatic cmp_all(input string ctl, input string dtag, input logic [8:0] act, input logic [8:0] exp, input string who);
    chk(ctl, {who, " modes"}, {act[8:5], 5'b0}, {exp[8:5], 5'b0});
    chk("R4", {who, " pulse"}, {4'b0, act[4], 4'b0}, {4'b0, exp[4], 4'b0});
    chk(exp[3] ? dtag : "R8", {who, " status"}, {5'b0, act[3:0]}, {5'b0, exp[3:0]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input string ctl, input string ta, input string tb, input bit mid);
    int len;
    logic [8:0] ea, eb;
    do_reset();
    gen(1'b1, qa, efa, eca);
    gen(1'b0, qb, efb, ecb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    len = (qa.size() > qb.size()) ? qa.size() : qb.size();
    for (int i = 0; i < len + 4; i++) begin
      ea = (i < qa.size()) ? qa[i] : {5'b0, 1'b1, efa, eca};
      eb = (i < qb.size()) ? qb[i] : {5'b0, 1'b1, efb, ecb};
      cmp_all(ctl, ta, {se_a, si_a, ld_a, cp_a, pu_a, dn_a, fl_a, cd_a}, ea, "dut");
      cmp_all(ctl, tb, {se_b, si_b, ld_b, cp_b, pu_b, dn_b, fl_b, cd_b}, eb, "dut_noext");
      start = mid && (i == 5);
      @(negedge clk);
    end
    start = 1'b0;
    brk_en = 0; v0_en = 0; v1_en = 0; lk_en = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle outputs after reset
    chk("R1", "dut reset", {se_a, si_a, ld_a, cp_a, pu_a, dn_a, fl_a, cd_a}, 9'b0);
    chk("R1", "dut_noext reset", {se_b, si_b, ld_b, cp_b, pu_b, dn_b, fl_b, cd_b}, 9'b0);

    // R7 clean die: all stages pass; R9 the no-extra variant stops after near-short
    run("R2 R3", "R7", "R9", 1'b0);
    // R6 R5: broken chain bit stuck high fails the chain check, no load cycle
    brk_en = 1; brk_pos = 3; brk_val = 1;
    run("R2 R6", "R5", "R5", 1'b0);
    // R5: via stuck low fails the stuck-at stage
    v0_en = 1; v0_pos = 2;
    run("R3", "R5", "R5", 1'b0);
    // R5 R4: leaky via fails only the near-short stage
    lk_en = 1; lk_pos = 5;
    run("R3 R4", "R5", "R5", 1'b0);
    // R9: via stuck high seen only by the extra stage
    v1_en = 1; v1_pos = 0;
    run("R3", "R5", "R9", 1'b0);
    // R8: start while busy is ignored
    run("R8", "R8", "R8", 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule